// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by reading two levels of translation tables from memory. The upper twelve address bits select a four-byte entry in a directory of 4096 entries whose base address is supplied on `dir_base`. A valid directory entry points to a second-level table of 256 four-byte entries, indexed by address bits 19:12. The selected page entry gives a 4 KB page frame. The frame is joined with the twelve offset bits to form the physical address, and the page entry also returns a 4-bit authority index that selects a per-page permission domain. A walk that reaches an invalid entry ends in a fault, and the fault level says whether the directory or the page table caused it.

Requests arrive one at a time through a valid/ready handshake. The walker issues each table read on a memory port that holds its request until it gets a one-cycle data strobe. The directory entry from the most recent successful directory read is kept in a one-entry walk cache, so a later address in the same 1 MB region skips the directory read. A flush port sets pending bits in an 18-bit vector. Bit 17 invalidates the walk cache. The pending bits clear by themselves once no walk is in flight, so software can poll until the vector reads zero. When `xlate_en` is low, accepted addresses are returned unchanged.

Top module: `iova_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid`, `mem_req` and `flush_pend` are all 0.
- R2: With `xlate_en` low at acceptance, `resp_valid` rises in the cycle after the accepting edge with `resp_pa` equal to the request address, `resp_aci` 0 and `resp_fault` 0, and no memory read is issued.
- R3: On a walk cache miss, the first memory read address is `dir_base + va[31:20]*4`. `mem_addr` stays stable while `mem_req` waits for `mem_rvalid`.
- R4: A directory entry is valid only when its bits 1:0 are 2'b01. Any other code ends the walk with `resp_fault`=1 and `resp_fault_lvl`=0 (level 1), issues no second read, and leaves the walk cache unchanged.
- R5: After a valid directory entry, the page entry is read at `{dte[31:10], 10'b0} + va[19:12]*4`.
- R6: A page entry with bit 1 clear ends the walk with `resp_fault`=1 and `resp_fault_lvl`=1 (level 2).
- R7: A page entry with bit 1 set yields `resp_pa = {pte[31:12], va[11:0]}` and `resp_aci = pte[7:4]`, with `resp_fault`=0.
- R8: After a successful directory read, a later request whose bits 31:20 match it skips the directory read, and its only memory read is the page entry.
- R9: A flush with bit 17 set invalidates the walk cache, so the next walk reads the directory again. A flush without bit 17 leaves the cache intact.
- R10: Written flush bits appear in `flush_pend` one cycle after the write. They clear one cycle later if no walk is in flight, and otherwise stay set until the walk's response has been given. `req_ready` is low while any bit is pending.
- R11: The walker serves one request at a time. After a translated request is accepted, `req_ready` stays low until its response, and `mem_req` is low whenever no walk is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Translation enable; low gives pass-through |
| dir_base | input | 32 | Directory table base address |
| flush_wr | input | 1 | Flush write strobe |
| flush_bits | input | 18 | Flush bits to set (bit 17 = walk cache) |
| flush_pend | output | 18 | Pending flush bits, self-clearing |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_pa | output | 32 | Physical address |
| resp_aci | output | 4 | Authority index from the page entry |
| resp_fault | output | 1 | Walk ended on an invalid entry |
| resp_fault_lvl | output | 1 | 0 = directory fault, 1 = page fault |
| mem_req | output | 1 | Table read request, held until data |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach is a flush that lands while a walk is waiting on memory. Here the pending bits must survive the walk and clear only after its response. The bench uses a memory model with a fixed latency of several cycles, starts a walk, and writes the flush while `mem_req` is still waiting. It then samples `flush_pend` in the response cycle and again one cycle later. The cache effects are checked at the port by logging every memory read address, which shows whether the directory read was skipped.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;
    localparam int VA_W           = 32;
    localparam int DIR_IDX_W      = 12;
    localparam int PT_IDX_W       = 8;
    localparam int ACI_W          = 4;
    localparam int FLUSH_W        = 18;
    localparam int FLUSH_WALK_BIT = 17;
    localparam int PTB_LSB        = 10;
    localparam logic [1:0] DTE_OK = 2'b01;
    localparam int PTE_VALID_BIT  = 1;
    localparam int ACI_LSB        = 4;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_DIR  = 2'd1,
        WK_PTE  = 2'd2
    } walk_st_e;
endpackage

// File: rtl/iova_walk_cache.sv
module iova_walk_cache #(
    parameter int TAG_W = 12,
    parameter int PTB_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [PTB_W-1:0] hit_ptb,
    input  logic             fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PTB_W-1:0] fill_ptb,
    input  logic             inv
);
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PTB_W-1:0] ptb;
    } ent_t;

    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (inv) begin
            ent_d.vld = 1'b0;
        end else if (fill) begin
            ent_d.vld = 1'b1;
            ent_d.tag = fill_tag;
            ent_d.ptb = fill_ptb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign hit     = ent_q.vld && (ent_q.tag == look_tag);
    assign hit_ptb = ent_q.ptb;

    // R9: an invalidate leaves nothing to hit on
    p_inv_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv |=> !hit);
    // R8: a fill is visible to a lookup of the same tag
    p_fill_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !inv) |=> (ent_q.vld && ent_q.tag == $past(fill_tag)));
endmodule

// File: rtl/iova_flush_ctl.sv
module iova_flush_ctl #(
    parameter int FL_W     = 18,
    parameter int WALK_BIT = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_wr,
    input  logic [FL_W-1:0] flush_bits,
    input  logic            busy,
    output logic [FL_W-1:0] pend,
    output logic            cache_inv,
    output logic            hold
);
    logic [FL_W-1:0] pend_d, pend_q;
    logic            done;

    assign done = (|pend_q) && !busy;

    always_comb begin
        pend_d = pend_q;
        if (done) pend_d = '0;
        if (flush_wr) pend_d = pend_d | flush_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend      = pend_q;
    assign hold      = |pend_q;
    assign cache_inv = done && pend_q[WALK_BIT];

    // R10: with no walk in flight, pending bits are gone one cycle later
    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pend_q) && !busy && !flush_wr) |=> (pend_q == '0));
    // R10: bits held while a walk is still running
    p_flush_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pend_q) && busy && !flush_wr) |=> (pend_q == $past(pend_q)));
endmodule

// File: rtl/iova_walk_fsm.sv
module iova_walk_fsm
    import iova_walk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DIR_W = 12,
    parameter int PT_W  = 8,
    parameter int AC_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xlate_en,
    input  logic [AW-1:0]         dir_base,
    input  logic                  hold,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AW-1:0]         req_va,
    output logic                  busy,
    output logic [DIR_W-1:0]      look_tag,
    input  logic                  c_hit,
    input  logic [AW-PTB_LSB-1:0] c_ptb,
    output logic                  c_fill,
    output logic [DIR_W-1:0]      c_fill_tag,
    output logic [AW-PTB_LSB-1:0] c_fill_ptb,
    output logic                  mem_req,
    output logic [AW-1:0]         mem_addr,
    input  logic                  mem_rvalid,
    input  logic [AW-1:0]         mem_rdata,
    output logic                  resp_valid,
    output logic [AW-1:0]         resp_pa,
    output logic [AC_W-1:0]       resp_aci,
    output logic                  resp_fault,
    output logic                  resp_fault_lvl
);
    localparam int OFS_W = AW - DIR_W - PT_W;
    localparam int PTB_W = AW - PTB_LSB;

    typedef struct packed {
        walk_st_e        st;
        logic [AW-1:0]   va;
        logic            mreq;
        logic [AW-1:0]   maddr;
        logic            rv;
        logic [AW-1:0]   pa;
        logic [AC_W-1:0] aci;
        logic            flt;
        logic            lvl;
    } wk_t;

    wk_t w_d, w_q;

    function automatic logic [AW-1:0] dir_addr(input logic [AW-1:0] base,
                                               input logic [AW-1:0] va);
        return base + {{(AW-DIR_W-2){1'b0}}, va[AW-1 -: DIR_W], 2'b00};
    endfunction

    function automatic logic [AW-1:0] pte_addr(input logic [PTB_W-1:0] ptb,
                                               input logic [AW-1:0] va);
        return {ptb, {PTB_LSB{1'b0}}}
             + {{(AW-PT_W-2){1'b0}}, va[OFS_W +: PT_W], 2'b00};
    endfunction

    assign look_tag   = req_va[AW-1 -: DIR_W];
    assign c_fill_tag = w_q.va[AW-1 -: DIR_W];
    assign c_fill_ptb = mem_rdata[AW-1:PTB_LSB];

    always_comb begin
        w_d    = w_q;
        w_d.rv = 1'b0;
        c_fill = 1'b0;
        unique case (w_q.st)
            WK_IDLE: begin
                if (req_valid && !hold) begin
                    w_d.va = req_va;
                    if (!xlate_en) begin
                        w_d.rv  = 1'b1;
                        w_d.pa  = req_va;
                        w_d.aci = '0;
                        w_d.flt = 1'b0;
                        w_d.lvl = 1'b0;
                    end else if (c_hit) begin
                        w_d.st    = WK_PTE;
                        w_d.mreq  = 1'b1;
                        w_d.maddr = pte_addr(c_ptb, req_va);
                    end else begin
                        w_d.st    = WK_DIR;
                        w_d.mreq  = 1'b1;
                        w_d.maddr = dir_addr(dir_base, req_va);
                    end
                end
            end
            WK_DIR: begin
                if (mem_rvalid) begin
                    if (mem_rdata[1:0] == DTE_OK) begin
                        c_fill    = 1'b1;
                        w_d.st    = WK_PTE;
                        w_d.maddr = pte_addr(mem_rdata[AW-1:PTB_LSB], w_q.va);
                    end else begin
                        w_d.st   = WK_IDLE;
                        w_d.mreq = 1'b0;
                        w_d.rv   = 1'b1;
                        w_d.pa   = '0;
                        w_d.aci  = '0;
                        w_d.flt  = 1'b1;
                        w_d.lvl  = 1'b0;
                    end
                end
            end
            WK_PTE: begin
                if (mem_rvalid) begin
                    w_d.st   = WK_IDLE;
                    w_d.mreq = 1'b0;
                    w_d.rv   = 1'b1;
                    if (mem_rdata[PTE_VALID_BIT]) begin
                        w_d.pa  = {mem_rdata[AW-1:OFS_W], w_q.va[OFS_W-1:0]};
                        w_d.aci = mem_rdata[ACI_LSB +: AC_W];
                        w_d.flt = 1'b0;
                        w_d.lvl = 1'b0;
                    end else begin
                        w_d.pa  = '0;
                        w_d.aci = '0;
                        w_d.flt = 1'b1;
                        w_d.lvl = 1'b1;
                    end
                end
            end
            default: w_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: WK_IDLE, default: '0};
        else        w_q <= w_d;
    end

    logic unused_rsvd;
    assign unused_rsvd = ^{mem_rdata[PTB_LSB-1:2], mem_rdata[0]};

    assign busy           = (w_q.st != WK_IDLE);
    assign req_ready      = !busy && !hold;
    assign mem_req        = w_q.mreq;
    assign mem_addr       = w_q.maddr;
    assign resp_valid     = w_q.rv;
    assign resp_pa        = w_q.pa;
    assign resp_aci       = w_q.aci;
    assign resp_fault     = w_q.flt;
    assign resp_fault_lvl = w_q.lvl;

    // R11: a translated request blocks the next one
    p_single_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xlate_en) |=> !req_ready);
    // R11: no memory traffic without a walk
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    // R3: read address held until data returns
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R2: pass-through answers next cycle with the same address
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlate_en) |=>
            (resp_valid && resp_pa == $past(req_va) && !resp_fault));
    // R10: a pending flush stops acceptance
    p_flush_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !req_ready);
endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import iova_walk_pkg::*;
#(
    parameter int AW       = VA_W,
    parameter int DIR_W    = DIR_IDX_W,
    parameter int PT_W     = PT_IDX_W,
    parameter int AC_W     = ACI_W,
    parameter int FL_W     = FLUSH_W,
    parameter int WALK_BIT = FLUSH_WALK_BIT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xlate_en,
    input  logic [AW-1:0]   dir_base,
    input  logic            flush_wr,
    input  logic [FL_W-1:0] flush_bits,
    output logic [FL_W-1:0] flush_pend,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_va,
    output logic            resp_valid,
    output logic [AW-1:0]   resp_pa,
    output logic [AC_W-1:0] resp_aci,
    output logic            resp_fault,
    output logic            resp_fault_lvl,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [AW-1:0]   mem_rdata
);
    localparam int PTB_W = AW - PTB_LSB;

    logic             busy, hold, c_inv, c_hit, c_fill;
    logic [DIR_W-1:0] look_tag, c_fill_tag;
    logic [PTB_W-1:0] c_ptb, c_fill_ptb;

    iova_flush_ctl #(.FL_W(FL_W), .WALK_BIT(WALK_BIT)) u_flush (
        .clk(clk), .rst_n(rst_n), .flush_wr(flush_wr), .flush_bits(flush_bits),
        .busy(busy), .pend(flush_pend), .cache_inv(c_inv), .hold(hold)
    );

    iova_walk_cache #(.TAG_W(DIR_W), .PTB_W(PTB_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .look_tag(look_tag), .hit(c_hit),
        .hit_ptb(c_ptb), .fill(c_fill), .fill_tag(c_fill_tag),
        .fill_ptb(c_fill_ptb), .inv(c_inv)
    );

    iova_walk_fsm #(.AW(AW), .DIR_W(DIR_W), .PT_W(PT_W), .AC_W(AC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .dir_base(dir_base),
        .hold(hold), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .busy(busy), .look_tag(look_tag), .c_hit(c_hit),
        .c_ptb(c_ptb), .c_fill(c_fill), .c_fill_tag(c_fill_tag),
        .c_fill_ptb(c_fill_ptb), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_aci(resp_aci),
        .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl)
    );
endmodule

// File: tb/sim_iova_walker.sv
`timescale 1ns/1ps
module sim_iova_walker;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic [31:0] dir_base = 32'h0010_0000;
    logic        flush_wr = 1'b0;
    logic [17:0] flush_bits = '0;
    logic [17:0] flush_pend;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        resp_valid;
    logic [31:0] resp_pa;
    logic [3:0]  resp_aci;
    logic        resp_fault, resp_fault_lvl;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [31:0] mem_a [logic [31:0]];
    logic [31:0] rd_log [8];
    int rd_cnt = 0;

    always #4 clk = ~clk;

    iova_walker u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder, acts on falling edges
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt == LAT) begin
                    mem_rdata = mem_a.exists(mem_addr) ? mem_a[mem_addr] : 32'h0;
                    if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                    mem_rvalid = 1'b1;
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    // issue one request; returns at the falling edge after acceptance
    task automatic issue(input logic [31:0] va);
        rd_cnt = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_resp();
        for (int i = 0; i < 60; i++) begin
            if (resp_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1", "req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1", "resp_valid", {31'b0, resp_valid}, 32'd0);
        chk("R1", "mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1", "flush_pend", {14'b0, flush_pend}, 32'd0);
    endtask

    task automatic t_bypass();
        xlate_en = 1'b0;
        issue(32'h1234_5678);
        chk("R2", "resp_valid", {31'b0, resp_valid}, 32'd1);
        chk("R2", "pa", resp_pa, 32'h1234_5678);
        chk("R2", "aci", {28'b0, resp_aci}, 32'd0);
        chk("R2", "fault", {31'b0, resp_fault}, 32'd0);
        chk("R2", "reads", rd_cnt, 0);
    endtask

    task automatic t_walk_ok();
        xlate_en = 1'b1;
        issue(32'hABC4_5123);
        chk("R11", "ready during walk", {31'b0, req_ready}, 32'd0);
        wait_resp();
        chk("R3", "dir read addr", rd_log[0], 32'h0010_2AF0);
        chk("R5", "pte read addr", rd_log[1], 32'h0040_0114);
        chk("R7", "pa", resp_pa, 32'h8765_4123);
        chk("R7", "aci", {28'b0, resp_aci}, 32'd5);
        chk("R7", "fault", {31'b0, resp_fault}, 32'd0);
    endtask

    task automatic t_cache_hit();
        issue(32'hABC4_6FFF);
        wait_resp();
        chk("R8", "read count", rd_cnt, 1);
        chk("R8", "pte addr", rd_log[0], 32'h0040_0118);
        chk("R8", "pa", resp_pa, 32'h1357_9FFF);
        chk("R8", "aci", {28'b0, resp_aci}, 32'd3);
    endtask

    task automatic t_flush_idle();
        @(negedge clk);
        flush_wr = 1'b1;
        flush_bits = 18'h2_0000;
        @(negedge clk);
        flush_wr = 1'b0;
        chk("R10", "pend set", {14'b0, flush_pend}, 32'h0002_0000);
        chk("R10", "ready while pending", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R10", "pend cleared", {14'b0, flush_pend}, 32'd0);
        issue(32'hABC4_6000);
        wait_resp();
        chk("R9", "read count after flush", rd_cnt, 2);
        chk("R9", "dir reread", rd_log[0], 32'h0010_2AF0);
    endtask

    task automatic t_flush_busy();
        issue(32'hABC4_5000);
        flush_wr = 1'b1;
        flush_bits = 18'h0_003F;
        @(negedge clk);
        flush_wr = 1'b0;
        chk("R10", "pend in walk", {14'b0, flush_pend}, 32'h3F);
        wait_resp();
        chk("R10", "pend at response", {14'b0, flush_pend}, 32'h3F);
        chk("R7", "pa under flush", resp_pa, 32'h8765_4000);
        @(negedge clk);
        chk("R10", "pend after walk", {14'b0, flush_pend}, 32'd0);
        issue(32'hABC4_5000);
        wait_resp();
        chk("R9", "cache kept w/o bit17", rd_cnt, 1);
    endtask

    task automatic t_dir_fault();
        issue(32'h0010_0000);
        wait_resp();
        chk("R4", "fault code11", {30'b0, resp_fault, resp_fault_lvl}, 32'b10);
        chk("R4", "reads code11", rd_cnt, 1);
        mem_a[32'h0010_0004] = 32'h0050_0002;
        issue(32'h0010_0ABC);
        wait_resp();
        chk("R4", "fault code10", {30'b0, resp_fault, resp_fault_lvl}, 32'b10);
        chk("R4", "dir reread not cached", rd_log[0], 32'h0010_0004);
        issue(32'h0030_0000);
        wait_resp();
        chk("R4", "empty entry fault", {30'b0, resp_fault, resp_fault_lvl}, 32'b10);
    endtask

    task automatic t_pte_fault();
        issue(32'h0020_0000);
        wait_resp();
        chk("R6", "fault lvl2", {30'b0, resp_fault, resp_fault_lvl}, 32'b11);
        chk("R5", "pte addr", rd_log[1], 32'h0060_0000);
    endtask

    initial begin
        mem_a[32'h0010_2AF0] = 32'h0040_0001;
        mem_a[32'h0040_0114] = 32'h8765_4A52;
        mem_a[32'h0040_0118] = 32'h1357_9F32;
        mem_a[32'h0010_0004] = 32'h0050_0003;
        mem_a[32'h0010_0008] = 32'h0060_0001;
        mem_a[32'h0060_0000] = 32'h1234_5FF1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_walk_ok();
        t_cache_hit();
        t_flush_idle();
        t_flush_busy();
        t_dir_fault();
        t_pte_fault();
        repeat (4) @(negedge clk);
        summary();
    end
endmodule